// File: doc/BRIEF.md
# Machine Cycle Rate Controller

This block sets how many oscillator clocks form one machine cycle. A two-bit selection picks 4, 64 or 1024 clocks per cycle, and a prescale counter emits a one-clock cycle strobe at the chosen rate. Software changes the selection through a simple write port. The block enforces the rules on which writes may take effect. A reduced rate can only be entered from the fast rate, and never while a serial transfer is in flight.

When automatic return is enabled, the block drops back to the fast rate by itself in two cases. The first is an enabled external interrupt whose priority would let it be serviced. The second is the leading edge of a serial start bit while the receiver is enabled. Each such forced return produces a one-clock pulse. The CPU, the UART and the interrupt controller stay outside the block and supply only flags and pulses.

Top module: `cycle_rate_ctrl`

## Requirements
- R1: After reset the selection reads 01 (4 clocks per cycle), and no switchback pulse is present.
- R2: A write of 10 (64 clocks) or 11 (1024 clocks) takes effect only when the current selection is 00 or 01. A write that changes directly between 10 and 11 leaves the selection unchanged.
- R3: A write of 00 or 01 (both meaning 4 clocks per cycle) is always stored, unless a switchback occurs in the same clock.
- R4: While rx_busy or tx_busy is 1, a write of 10 or 11 is ignored.
- R5: With swb_en at 1, a start_det pulse sets a start-seen state that blocks writes of 10 or 11. The block also applies in the same clock as the pulse. The state clears on the clock after rx_busy falls from 1 to 0.
- R6: cyc_stb is high for one clock every N clocks, where N is 4, 64 or 1024 for the current selection. The count restarts whenever the selection changes, so the first strobe comes N clocks after the change.
- R7: With swb_en and rx_en both 1, a start_det pulse forces the selection to 01 on the next edge. It has no such effect if rx_en is 0.
- R8: With swb_en at 1, an interrupt with irq_req and irq_en both set forces the selection to 01 if its level is above the current service level. Its 2-bit priority field gives the level: 00 is low, 01 is high, 1x is power-fail.
- R9: An interrupt at or below the current service level causes no switchback. The service level is the highest of power-fail, high and low that is flagged in service. With swb_en at 0, no switchback occurs at all.
- R10: When a write and a switchback fall in the same clock, the selection becomes 01.
- R11: swb_pulse is high for one clock exactly when a switchback moves the selection from 10 or 11 to 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe for the selection |
| wr_sel | input | 2 | Selection value written |
| swb_en | input | 1 | Enables automatic return to the fast rate |
| rx_en | input | 1 | Serial receiver enabled |
| start_det | input | 1 | One-clock pulse at a start-bit leading edge |
| rx_busy | input | 1 | Serial word being received |
| tx_busy | input | 1 | Serial word being shifted out |
| irq_req | input | NUM_IRQ | External interrupt requests |
| irq_en | input | NUM_IRQ | Per-interrupt enables |
| irq_prio | input | 2*NUM_IRQ | 2-bit priority field per interrupt |
| insvc_pf | input | 1 | Power-fail level in service |
| insvc_hi | input | 1 | High level in service |
| insvc_lo | input | 1 | Low level in service |
| sel | output | 2 | Current rate selection |
| cyc_stb | output | 1 | Machine-cycle strobe |
| swb_pulse | output | 1 | One-clock pulse on a forced return |

## Verification
Writes are tried from each current selection toward every target value. This separates the slow-to-slow rule from the always-accepted fast writes. The same slow writes are repeated with each busy flag raised, and again after a start pulse, so that each blocking source is shown to act alone. Switchbacks are driven by start pulses with the receiver on and off, and by interrupts at each priority against each in-service level. This separates a level that preempts from one that is locked out. A write collides with a switchback in the same clock, and long runs at 64 and 1024 check that the strobe restarts on every change of selection.

// File: rtl/cyc_rate_pkg.sv
package cyc_rate_pkg;

  localparam logic [1:0] SEL_FAST0  = 2'b00;
  localparam logic [1:0] SEL_FAST   = 2'b01;
  localparam logic [1:0] SEL_DIV64  = 2'b10;
  localparam logic [1:0] SEL_DIV1K  = 2'b11;

  // a selection is a reduced rate when its upper bit is set
  function automatic logic sel_is_slow(input logic [1:0] s);
    return s[1];
  endfunction

  // clocks per machine cycle for a selection
  function automatic int sel_divisor(input logic [1:0] s, input int d_fast,
                                     input int d_mid, input int d_slow);
    case (s)
      SEL_DIV64: return d_mid;
      SEL_DIV1K: return d_slow;
      default:   return d_fast;
    endcase
  endfunction

  // rank of an interrupt priority field: low 1, high 2, power-fail 3
  function automatic logic [1:0] prio_rank(input logic [1:0] p);
    if (p[1])      return 2'd3;
    else if (p[0]) return 2'd2;
    else           return 2'd1;
  endfunction

  // rank of the level now being serviced, 0 when none
  function automatic logic [1:0] service_rank(input logic pf, input logic hi,
                                              input logic lo);
    if (pf)      return 2'd3;
    else if (hi) return 2'd2;
    else if (lo) return 2'd1;
    else         return 2'd0;
  endfunction

endpackage

// File: rtl/cyc_swb_qual.sv
module cyc_swb_qual
  import cyc_rate_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic                 swb_en,
  input  logic                 rx_en,
  input  logic                 start_det,
  input  logic [NUM_IRQ-1:0]   irq_req,
  input  logic [NUM_IRQ-1:0]   irq_en,
  input  logic [2*NUM_IRQ-1:0] irq_prio,
  input  logic                 insvc_pf,
  input  logic                 insvc_hi,
  input  logic                 insvc_lo,
  output logic                 irq_fire,
  output logic                 start_fire,
  output logic                 swb_fire
);

  logic [1:0]         cur_rank;
  logic [NUM_IRQ-1:0] irq_hit;

  assign cur_rank = service_rank(insvc_pf, insvc_hi, insvc_lo);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic [1:0] own_rank;
    assign own_rank   = prio_rank(irq_prio[2*i +: 2]);
    assign irq_hit[i] = irq_req[i] & irq_en[i] & (own_rank > cur_rank);
  end

  assign irq_fire   = |irq_hit;
  assign start_fire = start_det & rx_en;
  assign swb_fire   = swb_en & (irq_fire | start_fire);

endmodule

// File: rtl/cyc_mode_reg.sv
module cyc_mode_reg
  import cyc_rate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic       swb_fire,
  input  logic       swb_en,
  input  logic       start_det,
  input  logic       rx_busy,
  input  logic       tx_busy,
  output logic [1:0] sel_q,
  output logic       sel_change,
  output logic       swb_pulse,
  output logic       wr_accept,
  output logic       slow_locked
);

  logic [1:0] sel_d;
  logic       start_seen_q;
  logic       rx_busy_q;
  logic       start_now;
  logic       target_slow;

  assign start_now   = swb_en & start_det;
  assign target_slow = sel_is_slow(wr_sel);
  assign slow_locked = rx_busy | tx_busy | start_seen_q | start_now |
                       sel_is_slow(sel_q);
  assign wr_accept   = wr_en & (!target_slow | !slow_locked);

  always_comb begin
    sel_d = sel_q;
    if (swb_fire)       sel_d = SEL_FAST;
    else if (wr_accept) sel_d = wr_sel;
  end

  assign sel_change = (sel_d != sel_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q        <= SEL_FAST;
      swb_pulse    <= 1'b0;
      start_seen_q <= 1'b0;
      rx_busy_q    <= 1'b0;
    end else begin
      sel_q     <= sel_d;
      swb_pulse <= swb_fire & sel_is_slow(sel_q);
      rx_busy_q <= rx_busy;
      if (start_now)               start_seen_q <= 1'b1;
      else if (rx_busy_q & !rx_busy) start_seen_q <= 1'b0;
    end
  end

endmodule

// File: rtl/cyc_prescaler.sv
module cyc_prescaler
  import cyc_rate_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 64,
  parameter int DIV_SLOW = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_q,
  input  logic       restart,
  output logic       cyc_stb
);

  localparam int CNT_W = $clog2(DIV_SLOW);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit   = CNT_W'(sel_divisor(sel_q, DIV_FAST, DIV_MID, DIV_SLOW) - 1);
  assign cyc_stb = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (cyc_stb)  cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/cycle_rate_ctrl.sv
module cycle_rate_ctrl
  import cyc_rate_pkg::*;
#(
  parameter int NUM_IRQ  = 4,
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 64,
  parameter int DIV_SLOW = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic                 swb_en,
  input  logic                 rx_en,
  input  logic                 start_det,
  input  logic                 rx_busy,
  input  logic                 tx_busy,
  input  logic [NUM_IRQ-1:0]   irq_req,
  input  logic [NUM_IRQ-1:0]   irq_en,
  input  logic [2*NUM_IRQ-1:0] irq_prio,
  input  logic                 insvc_pf,
  input  logic                 insvc_hi,
  input  logic                 insvc_lo,
  output logic [1:0]           sel,
  output logic                 cyc_stb,
  output logic                 swb_pulse
);

  logic irq_fire;
  logic start_fire;
  logic swb_fire;
  logic sel_change;
  logic wr_accept;
  logic slow_locked;

  cyc_swb_qual #(.NUM_IRQ(NUM_IRQ)) qual_i (
    .swb_en(swb_en), .rx_en(rx_en), .start_det(start_det),
    .irq_req(irq_req), .irq_en(irq_en), .irq_prio(irq_prio),
    .insvc_pf(insvc_pf), .insvc_hi(insvc_hi), .insvc_lo(insvc_lo),
    .irq_fire(irq_fire), .start_fire(start_fire), .swb_fire(swb_fire)
  );

  cyc_mode_reg mode_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .swb_fire(swb_fire), .swb_en(swb_en), .start_det(start_det),
    .rx_busy(rx_busy), .tx_busy(tx_busy),
    .sel_q(sel), .sel_change(sel_change), .swb_pulse(swb_pulse),
    .wr_accept(wr_accept), .slow_locked(slow_locked)
  );

  cyc_prescaler #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) pre_i (
    .clk(clk), .rst_n(rst_n), .sel_q(sel), .restart(sel_change),
    .cyc_stb(cyc_stb)
  );

endmodule

// File: rtl/cycle_rate_ctrl_chk.sv
module cycle_rate_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sel,
  input logic       cyc_stb,
  input logic       swb_pulse,
  input logic       swb_en,
  input logic       rx_busy,
  input logic       tx_busy,
  input logic       insvc_pf,
  input logic       irq_fire
);

  assert_no_slow_hop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel[1] |=> (!sel[1] || sel == $past(sel)));

  assert_busy_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_busy || tx_busy) && !sel[1]) |=> !sel[1]);

  assert_restart_on_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> !cyc_stb);

  assert_pf_locks_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    insvc_pf |-> !irq_fire);

  assert_pulse_lands_fast_R11: assert property (@(posedge clk) disable iff (!rst_n)
    swb_pulse |-> (sel == 2'b01 && $past(sel[1])));

  assert_no_pulse_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !swb_en |=> !swb_pulse);

endmodule

bind cycle_rate_ctrl cycle_rate_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sel(sel), .cyc_stb(cyc_stb),
  .swb_pulse(swb_pulse), .swb_en(swb_en), .rx_busy(rx_busy),
  .tx_busy(tx_busy), .insvc_pf(insvc_pf), .irq_fire(irq_fire)
);

// File: tb/cycle_rate_ctrl_tb_top.sv
`timescale 1ns/1ps
module cycle_rate_ctrl_tb_top;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'b00;
  logic swb_en = 1'b0, rx_en = 1'b0, start_det = 1'b0;
  logic rx_busy = 1'b0, tx_busy = 1'b0;
  logic [N-1:0] irq_req = '0, irq_en = '0;
  logic [2*N-1:0] irq_prio = '0;
  logic insvc_pf = 1'b0, insvc_hi = 1'b0, insvc_lo = 1'b0;
  logic [1:0] sel;
  logic cyc_stb, swb_pulse;

  always #2.5 clk = ~clk;

  cycle_rate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .swb_en(swb_en), .rx_en(rx_en), .start_det(start_det),
    .rx_busy(rx_busy), .tx_busy(tx_busy), .irq_req(irq_req),
    .irq_en(irq_en), .irq_prio(irq_prio), .insvc_pf(insvc_pf),
    .insvc_hi(insvc_hi), .insvc_lo(insvc_lo), .sel(sel),
    .cyc_stb(cyc_stb), .swb_pulse(swb_pulse)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit model_on = 1'b0;

  // behavioural reference
  int m_sel = 1, m_cnt = 0, m_pulse = 0;
  bit m_seen = 0, m_rxq = 0;

  function automatic int clocks_for(int s);
    if (s == 2) return 64;
    if (s == 3) return 1024;
    return 4;
  endfunction

  function automatic int level_of(logic [1:0] p);
    if (p >= 2) return 3;
    if (p == 1) return 2;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 1; m_cnt = 0; m_pulse = 0; m_seen = 0; m_rxq = 0;
    end else begin
      int lvl, nxt;
      bit hit, swb, slow, blk;
      lvl = insvc_pf ? 3 : insvc_hi ? 2 : insvc_lo ? 1 : 0;
      hit = 0;
      for (int i = 0; i < N; i++)
        if (irq_req[i] && irq_en[i] && level_of(irq_prio[2*i +: 2]) > lvl) hit = 1;
      swb  = swb_en && (hit || (start_det && rx_en));
      slow = (m_sel >= 2);
      blk  = rx_busy || tx_busy || m_seen || (swb_en && start_det) || slow;
      nxt  = m_sel;
      if (swb) nxt = 1;
      else if (wr_en && (wr_sel < 2 || !blk)) nxt = wr_sel;
      m_pulse = (swb && slow) ? 1 : 0;
      if (nxt != m_sel) m_cnt = 0;
      else if (m_cnt == clocks_for(m_sel) - 1) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      m_sel = nxt;
      if (swb_en && start_det) m_seen = 1;
      else if (m_rxq && !rx_busy) m_seen = 0;
      m_rxq = rx_busy;
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      cmp("sel", sel, m_sel);
      cmp("cyc_stb", cyc_stb, (m_cnt == clocks_for(m_sel) - 1) ? 1 : 0);
      cmp("swb_pulse", swb_pulse, m_pulse);
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write(logic [1:0] v);
    wr_en = 1'b1; wr_sel = v; tick(); wr_en = 1'b0; tick();
  endtask

  task automatic expect_sel(int exp, string tag);
    cur_req = tag;
    cmp("sel literal", sel, exp);
  endtask

  task automatic pulse_start();
    start_det = 1'b1; tick(); start_det = 1'b0;
  endtask

  task automatic fire_irq(int idx, logic [1:0] p);
    irq_prio[2*idx +: 2] = p; irq_en[idx] = 1'b1; irq_req[idx] = 1'b1;
    tick(); irq_req = '0; tick();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    model_on = 1'b1;
    // R1 reset state
    expect_sel(1, "R1"); cmp("pulse after reset", swb_pulse, 0);
    // R6 fast strobe rate
    cur_req = "R6"; tick(12);
    // R2 slow from fast, then slow-to-slow hop ignored
    cur_req = "R2"; write(2'b10); expect_sel(2, "R2"); tick(140);
    write(2'b11); expect_sel(2, "R2");
    // R3 fast writes always accepted
    write(2'b01); expect_sel(1, "R3");
    write(2'b11); expect_sel(3, "R2"); write(2'b10); expect_sel(3, "R2");
    cur_req = "R6"; tick(2100);
    write(2'b00); expect_sel(0, "R3"); tick(9);
    // R4 busy guards
    rx_busy = 1'b1; write(2'b10); expect_sel(0, "R4");
    rx_busy = 1'b0; tx_busy = 1'b1; write(2'b11); expect_sel(0, "R4");
    tx_busy = 1'b0; tick();
    // R5 start seen blocks, cleared by rx_busy falling
    swb_en = 1'b1; rx_en = 1'b0; pulse_start(); tick();
    write(2'b10); expect_sel(0, "R5");
    wr_en = 1'b1; wr_sel = 2'b11; start_det = 1'b1; tick();
    wr_en = 1'b0; start_det = 1'b0; tick(); expect_sel(0, "R5");
    rx_busy = 1'b1; tick(3); rx_busy = 1'b0; tick(2);
    write(2'b10); expect_sel(2, "R5");
    // R7 start switchback needs rx_en
    pulse_start(); tick(); expect_sel(2, "R7");
    rx_en = 1'b1; cur_req = "R11"; pulse_start(); expect_sel(1, "R7");
    rx_busy = 1'b1; tick(); rx_busy = 1'b0; tick(2); rx_en = 1'b0;
    // R8 / R9 interrupt switchback and lockout
    write(2'b11); expect_sel(3, "R8");
    fire_irq(0, 2'b00); expect_sel(1, "R8");
    write(2'b10); insvc_lo = 1'b1;
    fire_irq(1, 2'b00); expect_sel(2, "R9");
    fire_irq(2, 2'b01); expect_sel(1, "R8");
    write(2'b11); insvc_pf = 1'b1;
    fire_irq(3, 2'b10); expect_sel(3, "R9");
    insvc_pf = 1'b0; insvc_hi = 1'b1;
    fire_irq(0, 2'b01); expect_sel(3, "R9");
    insvc_hi = 1'b0; insvc_lo = 1'b0; swb_en = 1'b0;
    fire_irq(0, 2'b11); expect_sel(3, "R9");
    // R10 write and switchback in one clock
    swb_en = 1'b1;
    wr_en = 1'b1; wr_sel = 2'b00; irq_req[1] = 1'b1; irq_en[1] = 1'b1;
    tick(); wr_en = 1'b0; irq_req = '0; tick();
    expect_sel(1, "R10");
    cur_req = "R6"; tick(20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule